// File: doc/BRIEF.md
# Overcurrent Fault Latch with Clear Timer

This block turns two fault sources into a shutdown request for all six gate outputs of a three-phase bridge, and into an active-low fault flag. The first source is a digitized overcurrent comparator output. It passes through a persistence filter, so a trip that is too short to count is discarded. A trip that qualifies sets a set-dominant fault latch. The second source is a supply-undervoltage indication. It forces the fault for exactly as long as it is present and is never stored.

The latch can only be released by a clear timer. The timer stands in for an external capacitor that is recharged after an overcurrent event. While a qualified trip is present the timer is held at zero, and a discharge indication is raised. Once the trip ends the timer counts up. When it reaches the programmed interval the latch releases, and the gate outputs follow their normal inputs again. A trip that qualifies during the clear interval sets the latch again and restarts the timer from zero.

Top module: `oc_fault_guard`

## Requirements
- R1: After reset, faultN is 1, shutdown is 0 and timerDischarge is 0. The clear timer starts in the expired state.
- R2: A trip is qualified only when tripIn is sampled high on FILT_CYCLES consecutive clock edges. A shorter high run leaves faultN at 1 and timerDischarge at 0.
- R3: timerDischarge rises on the FILT_CYCLES-th consecutive high sample of tripIn. shutdown rises (and faultN falls) one clock edge later.
- R4: The latch is set-dominant. While the trip stays qualified, shutdown stays 1 for any duration, including durations longer than the clear interval.
- R5: timerDischarge is 1 exactly while the trip is qualified. It falls on the first clock edge that samples tripIn low.
- R6: After timerDischarge falls, the latched fault releases on the (CLEAR_CYCLES+1)-th clock edge after the edge that first sampled tripIn low, provided undervoltage is absent.
- R7: A trip that qualifies during the clear interval sets the latch again and restarts the timer. The release is then timed from the end of the new trip, as in R6.
- R8: uvIn drives faultN to 0 and shutdown to 1 combinationally, with no timer. Both release in the same cycle that uvIn falls, unless the overcurrent latch is still set.
- R9: faultN is the inverse of (latched overcurrent OR uvIn), and shutdown is always the inverse of faultN.
- R10: A tripIn pulse during the clear interval that is shorter than FILT_CYCLES neither restarts the timer nor delays the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tripIn | input | 1 | Digitized overcurrent comparator output, high = overcurrent |
| uvIn | input | 1 | Supply undervoltage indication, high = undervoltage |
| shutdown | output | 1 | Forces all six gate outputs low when 1 |
| faultN | output | 1 | Active-low fault flag (0 = fault) |
| timerDischarge | output | 1 | Clear timer held at zero (qualified trip present) |

## Verification
The bench builds the block with FILT_CYCLES = 4 and CLEAR_CYCLES = 20, in place of the long defaults. These values keep a full trip-and-release cycle to a few dozen clocks. That makes it cheap to measure release timing to the exact edge, to hold a trip longer than the whole clear interval, and to place a retrigger or a sub-filter glitch at chosen points inside the interval. A behavioural model, built from counts of consecutive samples, is compared with every output on every clock.

// File: rtl/oc_fault_pkg.sv
package oc_fault_pkg;
  // strobes from control to the timer datapath
  typedef struct packed {
    logic holdZero;   // qualified trip present: discharge timer
  } ctlStrobes_t;
endpackage

// File: rtl/oc_clear_timer.sv
module oc_clear_timer
  import oc_fault_pkg::*;
#(
  parameter int CLEAR_CYCLES = 190000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  output logic        expired
);
  localparam int CW = $clog2(CLEAR_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CLEAR_CYCLES);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= LIMIT;
    end else if (strobes.holdZero) begin
      count <= '0;
    end else if (count != LIMIT) begin
      count <= count + 1'b1;
    end
  end

  assign expired = (count == LIMIT);
endmodule

// File: rtl/oc_fault_ctrl.sv
module oc_fault_ctrl
  import oc_fault_pkg::*;
#(
  parameter int FILT_CYCLES = 23
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tripIn,
  input  logic        uvIn,
  input  logic        expired,
  output ctlStrobes_t strobes,
  output logic        shutdown,
  output logic        faultN,
  output logic        timerDischarge
);
  logic tripQual;
  logic ocLatch;

  // persistence filter on the trip input
  generate
    if (FILT_CYCLES <= 1) begin : g_noFilt
      always_ff @(posedge clk) begin
        if (!rstN) tripQual <= 1'b0;
        else       tripQual <= tripIn;
      end
    end else begin : g_filt
      localparam int FW = $clog2(FILT_CYCLES);
      localparam logic [FW-1:0] LAST = FW'(FILT_CYCLES - 1);
      logic [FW-1:0] runCnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          runCnt   <= '0;
          tripQual <= 1'b0;
        end else if (!tripIn) begin
          runCnt   <= '0;
          tripQual <= 1'b0;
        end else if (runCnt == LAST) begin
          tripQual <= 1'b1;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end
    end
  endgenerate

  // set-dominant fault latch
  always_ff @(posedge clk) begin
    if (!rstN)         ocLatch <= 1'b0;
    else if (tripQual) ocLatch <= 1'b1;
    else if (expired)  ocLatch <= 1'b0;
  end

  always_comb begin
    strobes.holdZero = tripQual;
    shutdown         = ocLatch | uvIn;
    faultN           = ~shutdown;
    timerDischarge   = tripQual;
  end
endmodule

// File: rtl/oc_fault_guard.sv
module oc_fault_guard
  import oc_fault_pkg::*;
#(
  parameter int FILT_CYCLES  = 23,
  parameter int CLEAR_CYCLES = 190000
) (
  input  logic clk,
  input  logic rstN,
  input  logic tripIn,
  input  logic uvIn,
  output logic shutdown,
  output logic faultN,
  output logic timerDischarge
);
  ctlStrobes_t strobes;
  logic        expired;

  oc_fault_ctrl #(.FILT_CYCLES(FILT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tripIn(tripIn), .uvIn(uvIn),
    .expired(expired), .strobes(strobes), .shutdown(shutdown),
    .faultN(faultN), .timerDischarge(timerDischarge)
  );

  oc_clear_timer #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_timer (
    .clk(clk), .rstN(rstN), .strobes(strobes), .expired(expired)
  );
endmodule

// File: rtl/oc_fault_guard_chk.sv
module oc_fault_guard_chk #(
  parameter int CLEAR_CYCLES = 190000
) (
  input logic clk,
  input logic rstN,
  input logic tripIn,
  input logic uvIn,
  input logic shutdown,
  input logic faultN,
  input logic timerDischarge
);
  localparam int QW = $clog2(CLEAR_CYCLES + 2);
  localparam logic [QW-1:0] QMAX = QW'(CLEAR_CYCLES + 1);

  // edges since the discharge indication was last seen high
  logic [QW-1:0] quietCnt;
  always_ff @(posedge clk) begin
    if (!rstN)               quietCnt <= QMAX;
    else if (timerDischarge) quietCnt <= '0;
    else if (quietCnt != QMAX) quietCnt <= quietCnt + 1'b1;
  end

  a_r9_complement: assert property (@(posedge clk) disable iff (!rstN)
    shutdown == !faultN);
  a_r8_uv_forces: assert property (@(posedge clk) disable iff (!rstN)
    uvIn |-> (!faultN && shutdown));
  a_r2_needs_trip: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerDischarge) |-> $past(tripIn));
  a_r5_drop_on_low: assert property (@(posedge clk) disable iff (!rstN)
    !tripIn |=> !timerDischarge);
  a_r3_sets_latch: assert property (@(posedge clk) disable iff (!rstN)
    timerDischarge |=> shutdown);
  a_r6_release_time: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultN) |-> (quietCnt == QMAX));
endmodule

bind oc_fault_guard oc_fault_guard_chk #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .tripIn(tripIn), .uvIn(uvIn),
  .shutdown(shutdown), .faultN(faultN), .timerDischarge(timerDischarge)
);

// File: tb/oc_fault_guard_bench.sv
module oc_fault_guard_bench;
  localparam int PERIOD = 10;
  localparam int F = 4;
  localparam int C = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tripIn = 1'b0;
  logic uvIn = 1'b0;
  logic shutdown, faultN, timerDischarge;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  oc_fault_guard #(.FILT_CYCLES(F), .CLEAR_CYCLES(C)) u_oc_fault_guard (
    .clk(clk), .rstN(rstN), .tripIn(tripIn), .uvIn(uvIn),
    .shutdown(shutdown), .faultN(faultN), .timerDischarge(timerDischarge)
  );

  // behavioural reference: counts of consecutive samples
  int hiRun, quiet;
  bit qual, latched;
  always @(posedge clk) begin
    int nHi, nQuiet;
    bit nLatch;
    if (!rstN) begin
      hiRun = 0; qual = 0; quiet = C; latched = 0;
    end else begin
      nQuiet = qual ? 0 : ((quiet < C) ? quiet + 1 : C);
      nLatch = qual ? 1'b1 : ((quiet == C) ? 1'b0 : latched);
      nHi    = tripIn ? hiRun + 1 : 0;
      hiRun = nHi; quiet = nQuiet; latched = nLatch;
      qual  = (nHi >= F);
    end
  end

  task automatic check(string req, logic act, logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R5 discharge", timerDischarge, qual);
    check("R9 faultN", faultN, !(latched || uvIn));
    check("R9 shutdown", shutdown, latched || uvIn);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic waitRelease(output int n);
    n = 0;
    while (faultN !== 1'b1 && n < 4 * C) begin
      cyc();
      n++;
    end
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    cyc();
    check("R1 faultN", faultN, 1'b1);
    check("R1 shutdown", shutdown, 1'b0);
    check("R1 discharge", timerDischarge, 1'b0);

    // R2: a run one short of the filter is discarded
    tripIn = 1'b1;
    repeat (F - 1) cyc();
    tripIn = 1'b0;
    repeat (3) cyc();
    check("R2 faultN", faultN, 1'b1);
    check("R2 discharge", timerDischarge, 1'b0);

    // R3: qualify, then latch one edge later
    tripIn = 1'b1;
    repeat (F) cyc();
    check("R3 discharge", timerDischarge, 1'b1);
    check("R3 no shutdown yet", shutdown, 1'b0);
    cyc();
    check("R3 shutdown", shutdown, 1'b1);
    check("R3 faultN", faultN, 1'b0);

    // R4: held trip longer than the clear interval
    repeat (C + 10) cyc();
    check("R4 shutdown held", shutdown, 1'b1);

    // R5 and R6: release timing after the trip ends
    tripIn = 1'b0;
    cyc();
    check("R5 discharge drop", timerDischarge, 1'b0);
    n = 1;
    begin
      int m;
      waitRelease(m);
      n += m;
    end
    check("R6 release cycles", n == C + 2, 1'b1);
    if (n != C + 2) $display("FAIL R6: actual %0d expected %0d", n, C + 2);

    // R7: retrigger inside the clear interval
    tripIn = 1'b1;
    repeat (F + 3) cyc();
    tripIn = 1'b0;
    repeat (10) cyc();
    check("R7 still latched", shutdown, 1'b1);
    tripIn = 1'b1;
    repeat (F + 2) cyc();
    tripIn = 1'b0;
    waitRelease(n);
    check("R7 release cycles", n == C + 2, 1'b1);
    if (n != C + 2) $display("FAIL R7: actual %0d expected %0d", n, C + 2);

    // R10: sub-filter glitch inside the interval does not restart timer
    tripIn = 1'b1;
    repeat (F + 1) cyc();
    tripIn = 1'b0;
    repeat (5) cyc();
    tripIn = 1'b1;
    repeat (F - 1) cyc();
    tripIn = 1'b0;
    waitRelease(n);
    n += 5 + (F - 1);
    check("R10 release cycles", n == C + 2, 1'b1);
    if (n != C + 2) $display("FAIL R10: actual %0d expected %0d", n, C + 2);

    // R8: undervoltage acts at once and releases at once
    repeat (3) cyc();
    uvIn = 1'b1;
    #1;
    check("R8 uv faultN", faultN, 1'b0);
    check("R8 uv shutdown", shutdown, 1'b1);
    repeat (C + 5) cyc();
    uvIn = 1'b0;
    #1;
    check("R8 uv release", faultN, 1'b1);
    cyc();

    // R8/R9: uv removed while overcurrent latch still set
    tripIn = 1'b1;
    repeat (F + 1) cyc();
    uvIn = 1'b1;
    tripIn = 1'b0;
    repeat (3) cyc();
    uvIn = 1'b0;
    #1;
    check("R9 latch keeps fault", faultN, 1'b0);
    repeat (C + 5) cyc();
    check("R9 final release", faultN, 1'b1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      vecs++;
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule